// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block sets the spacing of DRAM refresh cycles. An up-counter advances on each cycle in which the prescaler enable input `tick` is high. After every increment, the new count is checked against an 8-bit compare value. When the two are equal, the counter goes back to zero and a sticky compare flag is set. Two more effects depend on enable bits. If refresh is enabled, a one-cycle CAS-before-RAS refresh request pulse is issued. If the interrupt is enabled, the interrupt output is asserted. The refresh sequencer that acts on the request lies outside this block.

Software reaches the block through a small 16-bit register bus with per-byte write enables. The bus has no back-pressure: a write is accepted in the cycle `bus_wr` is high, and read data is a combinational function of `bus_addr`. There are three registers.

- Address 0 is control and status: bit 0 is the flag, bit 1 the interrupt enable and bit 2 the refresh enable.
- Address 1 returns the count.
- Address 2 holds the compare value, in bits 7..0, and is guarded by a key: it takes new data only from a full-word write whose upper byte is 0x96.

Address 3 reads as zero. There are two active-low asynchronous resets. `por_n` initialises everything. `mrst_n` initialises everything except the compare value.

Top module: `rit_refresh_timer`

## Requirements
- R1: While `por_n` is low and after it is released, address 2 reads 0x00FF, address 1 reads 0, address 0 reads 0, and `refresh_req` and `cmp_irq` are 0.
- R2: A write to address 2 with `bus_be` = 2'b11 and `bus_wdata[15:8]` = 0x96 loads `bus_wdata[7:0]` as the compare value from the next cycle. Bits 15..8 of address 2 always read 0.
- R3: A write to address 2 is ignored, leaving the compare value unchanged, if `bus_be` is not 2'b11 or if the upper byte is not 0x96.
- R4: `mrst_n` low clears the count, the flag and both enables, and leaves the compare value unchanged.
- R5: The count increments by one only at clock edges where `tick` is high. Otherwise it holds.
- R6: At an edge where `tick` is high and count+1 equals the compare value, the count becomes 0 and the flag (address 0 bit 0) becomes 1. The interval is therefore the compare value in ticks.
- R7: `refresh_req` is high for exactly the one cycle after a matching edge, and only if the refresh enable (address 0 bit 2) is 1.
- R8: `cmp_irq` is high exactly when the flag and the interrupt enable (address 0 bit 1) are both 1. The flag stays set until a write to address 0 with `bus_be[0]` = 1 and `bus_wdata[0]` = 0. Writing 1 to bit 0 has no effect on the flag.
- R9: If a match and a flag-clearing write occur at the same edge, the flag ends up set.
- R10: The count wraps from 0xFF to 0 without a match unless the compare value is 0. A compare value of 0 gives a 256-tick interval. A compare value written below the current count takes effect after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, asynchronous |
| tick | input | 1 | Prescaler enable: counter advances when high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_be | input | 2 | Byte enables, bit 1 for the upper byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| refresh_req | output | 1 | One-cycle refresh request pulse |
| cmp_irq | output | 1 | Compare-match interrupt |

## Verification
The hardest situations to reach are those where the count sits on the far side of the compare value. This happens when the compare value is written below the current count, or when the compare value is 0. In both cases the block has to wrap without matching, and then match later. To reach this, the bench programs a high compare value, runs the count past the intended target, and reprograms a low value through a keyed write. It then supplies the few hundred ticks needed to wrap and confirms that no flag is set until the new interval completes. The match-versus-clear collision is produced by issuing a tick and a flag-clearing write in the same cycle, with the counter one step below the compare value.

// File: rtl/rit_pkg.sv
package rit_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_CONST = 2'd2,
    ADDR_NONE  = 2'd3
  } rit_addr_e;

  localparam int CTRL_FLAG_BIT = 0;
  localparam int CTRL_IRQ_BIT  = 1;
  localparam int CTRL_REF_BIT  = 2;

  typedef struct packed {
    logic ref_en;
    logic irq_en;
    logic flag;
  } rit_ctrl_t;
endpackage

// File: rtl/rit_counter.sv
module rit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             mrst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             ref_en,
  output logic [CNT_W-1:0] cnt,
  output logic             match,
  output logic             refresh_req
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             refresh_q;

  assign cnt_inc = cnt_q + CNT_W'(1);
  assign match   = tick && (cnt_inc == cmp_val);

  always_ff @(posedge clk or negedge por_n or negedge mrst_n) begin
    if (!por_n || !mrst_n) begin
      cnt_q     <= '0;
      refresh_q <= 1'b0;
    end else begin
      if (tick) cnt_q <= match ? '0 : cnt_inc;
      refresh_q <= match && ref_en;
    end
  end

  assign cnt         = cnt_q;
  assign refresh_req = refresh_q;
endmodule

// File: rtl/rit_regfile.sv
module rit_regfile
  import rit_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter int          CNT_W      = 8,
  parameter logic [7:0]  KEY        = 8'h96,
  parameter int          CONST_INIT = 255
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              match,
  input  logic [CNT_W-1:0]  cnt,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  cmp_val,
  output rit_ctrl_t         ctrl
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int PAD_W  = DATA_W - CNT_W;
  localparam int CTL_W  = $bits(rit_ctrl_t);

  logic [CNT_W-1:0] cmp_q;
  rit_ctrl_t        ctrl_q;
  logic             ctrl_wr;
  logic             const_wr;

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL) && bus_be[0];
  assign const_wr = bus_wr && (bus_addr == ADDR_CONST) && (bus_be == 2'b11)
                    && (bus_wdata[DATA_W-1:BYTE_W] == KEY);

  // Compare value survives manual reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        cmp_q <= CNT_W'(CONST_INIT);
    else if (const_wr) cmp_q <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge por_n or negedge mrst_n) begin
    if (!por_n || !mrst_n) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.irq_en <= bus_wdata[CTRL_IRQ_BIT];
        ctrl_q.ref_en <= bus_wdata[CTRL_REF_BIT];
      end
      // set from a match outranks a software clear
      if (match)
        ctrl_q.flag <= 1'b1;
      else if (ctrl_wr && !bus_wdata[CTRL_FLAG_BIT])
        ctrl_q.flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTRL: begin
        bus_rdata[CTL_W-1:0]       = '0;
        bus_rdata[CTRL_FLAG_BIT]   = ctrl_q.flag;
        bus_rdata[CTRL_IRQ_BIT]    = ctrl_q.irq_en;
        bus_rdata[CTRL_REF_BIT]    = ctrl_q.ref_en;
      end
      ADDR_COUNT: bus_rdata = {{PAD_W{1'b0}}, cnt};
      ADDR_CONST: bus_rdata = {{PAD_W{1'b0}}, cmp_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign cmp_val = cmp_q;
  assign ctrl    = ctrl_q;
endmodule

// File: rtl/rit_refresh_timer.sv
module rit_refresh_timer
  import rit_pkg::*;
#(
  parameter int         DATA_W     = 16,
  parameter int         CNT_W      = 8,
  parameter logic [7:0] KEY        = 8'h96,
  parameter int         CONST_INIT = 255
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [1:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              refresh_req,
  output logic              cmp_irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp_val;
  logic             match;
  logic             flag;
  rit_ctrl_t        ctrl;

  rit_regfile #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY(KEY), .CONST_INIT(CONST_INIT)
  ) u_regs (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .match(match), .cnt(cnt),
    .bus_rdata(bus_rdata), .cmp_val(cmp_val), .ctrl(ctrl)
  );

  rit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .tick(tick),
    .cmp_val(cmp_val), .ref_en(ctrl.ref_en),
    .cnt(cnt), .match(match), .refresh_req(refresh_req)
  );

  assign flag    = ctrl.flag;
  assign cmp_irq = ctrl.flag && ctrl.irq_en;
endmodule

// File: rtl/rit_refresh_timer_chk.sv
module rit_refresh_timer_chk #(
  parameter int         DATA_W = 16,
  parameter int         CNT_W  = 8,
  parameter logic [7:0] KEY    = 8'h96
) (
  input logic              clk,
  input logic              por_n,
  input logic              mrst_n,
  input logic              tick,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [1:0]        bus_be,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  cmp_val,
  input logic              flag,
  input logic              refresh_req,
  input logic              cmp_irq
);
  logic any_rst;
  logic key_wr;
  logic clr_wr;
  assign any_rst = !por_n || !mrst_n;
  assign key_wr  = bus_wr && (bus_addr == 2'd2) && (bus_be == 2'b11)
                   && (bus_wdata[DATA_W-1:DATA_W/2] == KEY);
  assign clr_wr  = bus_wr && (bus_addr == 2'd0) && bus_be[0] && !bus_wdata[0];

  a_r3_const_guard: assert property (@(posedge clk) disable iff (!por_n)
    (cmp_val != $past(cmp_val)) |-> $past(key_wr));

  a_r5_hold: assert property (@(posedge clk) disable iff (any_rst)
    !tick |=> (cnt == $past(cnt)));

  a_r6_step: assert property (@(posedge clk) disable iff (any_rst)
    (cnt != $past(cnt)) |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)));

  a_r6_flag_needs_tick: assert property (@(posedge clk) disable iff (any_rst)
    $rose(flag) |-> $past(tick));

  a_r7_pulse_at_zero: assert property (@(posedge clk) disable iff (any_rst)
    refresh_req |-> ((cnt == '0) && flag));

  a_r8_sticky: assert property (@(posedge clk) disable iff (any_rst)
    (flag && !clr_wr) |=> flag);

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (any_rst)
    cmp_irq |-> flag);
endmodule

bind rit_refresh_timer rit_refresh_timer_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY(KEY)
) u_chk (
  .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .tick(tick),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .cnt(cnt), .cmp_val(cmp_val), .flag(flag),
  .refresh_req(refresh_req), .cmp_irq(cmp_irq)
);

// File: tb/rit_refresh_timer_test.sv
`timescale 1ns/1ps
module rit_refresh_timer_test;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        mrst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        refresh_req;
  logic        cmp_irq;

  int nchecks = 0;
  int nerrs   = 0;
  bit done    = 1'b0;

  string       tag_q[$];
  int          kind_q[$];
  logic [15:0] exp_q[$];

  always #4 clk = ~clk;

  rit_refresh_timer uut (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .tick(tick),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .refresh_req(refresh_req), .cmp_irq(cmp_irq)
  );

  // monitor: kind 0 = register read, 1 = refresh_req, 2 = cmp_irq
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      string       t;
      int          k;
      logic [15:0] e;
      logic [15:0] act;
      t = tag_q.pop_front();
      k = kind_q.pop_front();
      e = exp_q.pop_front();
      act = (k == 0) ? bus_rdata : (k == 1) ? {15'b0, refresh_req} : {15'b0, cmp_irq};
      nchecks++;
      if (act !== e) begin
        nerrs++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, act, e);
      end
    end
  end

  task automatic expect_item(input string t, input int k, input logic [1:0] a,
                             input logic [15:0] e);
    bus_addr = a;
    tag_q.push_back(t);
    kind_q.push_back(k);
    exp_q.push_back(e);
    @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic chk_reg(input string t, input logic [1:0] a, input logic [15:0] e);
    expect_item(t, 0, a, e);
  endtask

  task automatic chk_pin(input string t, input int k, input logic e);
    expect_item(t, k, bus_addr, {15'b0, e});
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nerrs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerrs, nchecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 por_n = 1'b1; mrst_n = 1'b1;

    // R1 reset state
    chk_reg("R1", 2'd2, 16'h00FF);
    chk_reg("R1", 2'd1, 16'h0000);
    chk_reg("R1", 2'd0, 16'h0000);
    chk_pin("R1", 1, 1'b0);
    chk_pin("R1", 2, 1'b0);

    // R2 keyed word write
    wr(2'd2, 2'b11, 16'h9603);
    chk_reg("R2", 2'd2, 16'h0003);
    chk_reg("R2", 2'd3, 16'h0000);

    // R3 ignored writes
    wr(2'd2, 2'b01, 16'h9605);
    chk_reg("R3", 2'd2, 16'h0003);
    wr(2'd2, 2'b10, 16'h9606);
    chk_reg("R3", 2'd2, 16'h0003);
    wr(2'd2, 2'b11, 16'h9507);
    chk_reg("R3", 2'd2, 16'h0003);

    // R5 counting only on tick
    wr(2'd0, 2'b01, 16'h0006);
    chk_reg("R8", 2'd0, 16'h0006);
    idle(4);
    chk_reg("R5", 2'd1, 16'h0000);
    ticks(1);
    chk_reg("R5", 2'd1, 16'h0001);
    idle(3);
    chk_reg("R5", 2'd1, 16'h0001);

    // R6 / R7 match at compare value 3
    ticks(2);
    chk_pin("R7", 1, 1'b1);
    chk_pin("R7", 1, 1'b0);
    chk_reg("R6", 2'd1, 16'h0000);
    chk_reg("R6", 2'd0, 16'h0007);
    chk_pin("R8", 2, 1'b1);

    // R8 sticky flag, write-1 no effect, write-0 clears
    wr(2'd0, 2'b01, 16'h0007);
    chk_reg("R8", 2'd0, 16'h0007);
    wr(2'd0, 2'b01, 16'h0006);
    chk_reg("R8", 2'd0, 16'h0006);
    chk_pin("R8", 2, 1'b0);

    // R9 match and clear together
    ticks(2);
    tick = 1'b1;
    wr(2'd0, 2'b01, 16'h0006);
    tick = 1'b0;
    chk_reg("R9", 2'd0, 16'h0007);

    // R7 refresh disabled, R8 irq disabled
    wr(2'd0, 2'b01, 16'h0000);
    ticks(3);
    chk_pin("R7", 1, 1'b0);
    chk_reg("R6", 2'd0, 16'h0001);
    chk_pin("R8", 2, 1'b0);

    // R4 manual reset
    ticks(1);
    wr(2'd0, 2'b01, 16'h0006);
    mrst_n = 1'b0;
    idle(1);
    mrst_n = 1'b1;
    chk_reg("R4", 2'd2, 16'h0003);
    chk_reg("R4", 2'd1, 16'h0000);
    chk_reg("R4", 2'd0, 16'h0000);

    // R10 compare value zero gives a full wrap
    wr(2'd2, 2'b11, 16'h9600);
    ticks(255);
    chk_reg("R10", 2'd1, 16'h00FF);
    chk_reg("R10", 2'd0, 16'h0000);
    ticks(1);
    chk_reg("R10", 2'd1, 16'h0000);
    chk_reg("R10", 2'd0, 16'h0001);

    // R10 compare value lowered below count
    wr(2'd0, 2'b01, 16'h0000);
    wr(2'd2, 2'b11, 16'h9640);
    ticks(32);
    chk_reg("R10", 2'd1, 16'h0020);
    wr(2'd2, 2'b11, 16'h9605);
    ticks(223);
    chk_reg("R10", 2'd1, 16'h00FF);
    ticks(1);
    chk_reg("R10", 2'd1, 16'h0000);
    chk_reg("R10", 2'd0, 16'h0000);
    ticks(5);
    chk_reg("R10", 2'd0, 16'h0001);
    chk_reg("R10", 2'd1, 16'h0000);

    // R1 power-on reset restores the compare value
    por_n = 1'b0;
    idle(1);
    por_n = 1'b1;
    chk_reg("R1", 2'd2, 16'h00FF);
    chk_reg("R1", 2'd0, 16'h0000);

    idle(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerrs, nchecks);
    $finish;
  end
endmodule